// File: doc/BRIEF.md
# Cascadable Up-Counting Timer with Trigger Output

This block is an up-counting timer whose counter is clocked through a programmable prescaler. It counts from zero up to a reload limit, then wraps back to zero. That wrap is the update event. A single compare channel produces a reference level from the counter value. A small write-only register port sets the divide value, the reload limit, the compare threshold, the compare polarity, the enable bit and a 3-bit master-mode code.

The master-mode code decides what appears on the one-bit trigger output, which feeds other timers. One code gives a pulse once per update event, so a second timer can use the output as a slow clock. Codes with the top bit set pass the compare reference through, so the output can gate another timer or clock it on compare edges. The divide value and the reload limit are double-buffered. Values written while the timer runs take effect only at the next update event, so the running period is never torn.

Top module: `cascade_timer`

## Requirements
- R1: After a synchronous reset, `cnt_o`, `oc_ref_o` and `trig_o` are 0. The enable bit, master-mode code, polarity, divide value and compare value reset to 0, and the reload limit resets to all ones.
- R2: A write with `wr_en` high loads `wr_data` into the register picked by `wr_addr`. Address 0 is control: bit 0 enable, bits 3:1 master-mode code, bit 4 compare polarity. Address 1 is the divide value P, address 2 is the reload limit A, and address 3 is the compare value C.
- R3: While the enable bit is 0, `cnt_o` holds its value.
- R4: While enabled, the counter advances exactly once every P+1 clocks, so two advances are never adjacent when P is at least 1.
- R5: The counter steps 0, 1, …, A. The advance taken at A (or above) returns it to 0, and that advance is the update event.
- R6: P and A written while enabled take effect only after the next update event. While disabled they take effect on the next clock.
- R7: With polarity 0, `oc_ref_o` is high exactly while the counter is below C, so C = 0 keeps it low. Polarity 1 inverts it. It lags the counter by one clock.
- R8: With master-mode code 3'b010, `trig_o` rises once per update event and stays high for P+1 clocks. Its rising edges are (P+1)(A+1) clocks apart.
- R9: With a master-mode code of the form 3'b1xx, `trig_o` carries the compare reference.
- R10: With any other master-mode code, `trig_o` is held low.
- R11: `trig_o` is a register: in modes 3'b1xx it equals the value `oc_ref_o` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| oc_ref_o | output | 1 | Compare reference level |
| trig_o | output | 1 | Trigger output for other timers |

## Verification
The table-driven phase programs different divide values, reload limits, compare values, polarities and master-mode codes. It measures the spacing and width of the trigger pulses for each setting. Update-pulse rows are distinguished from compare-reference rows by a width of P+1 versus C(P+1). Inverted-polarity rows are distinguished by a width of (A+1-C)(P+1). Rows with a zero compare value, an over-range compare value or a non-trigger code must yield a flat output with the right level. Directed tests then show that the divide ratio sets the count rate, that a disabled counter freezes, and that a reload value written mid-run waits for the wrap. A cycle-by-cycle comparison confirms the one-clock lag of the trigger output behind the reference.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] A_TOP  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd3;

  localparam logic [2:0] MM_UPDATE = 3'b010;

  typedef struct packed {
    logic       pol;
    logic [2:0] mm;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/cascade_timer_regs.sv
module cascade_timer_regs
  import cascade_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              upd,
  output ctrl_t             ctrl,
  output logic [W-1:0]      div_act,
  output logic [W-1:0]      top_act,
  output logic [W-1:0]      cmp_val
);
  localparam int CW = $bits(ctrl_t);

  logic [W-1:0] div_pre;
  logic [W-1:0] top_pre;
  logic         load_shadow;

  assign load_shadow = !ctrl.en || upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      div_pre <= '0;
      top_pre <= '1;
      cmp_val <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl    <= ctrl_t'(wr_data[CW-1:0]);
        A_DIV:   div_pre <= wr_data;
        A_TOP:   top_pre <= wr_data;
        default: cmp_val <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_act <= '0;
      top_act <= '1;
    end else if (load_shadow) begin
      div_act <= div_pre;
      top_act <= top_pre;
    end
  end
endmodule

// File: rtl/cascade_timer_cnt.sv
module cascade_timer_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] div_act,
  input  logic [W-1:0] top_act,
  output logic [W-1:0] cnt,
  output logic         tick,
  output logic         wrap
);
  logic [W-1:0] pcnt;

  assign tick = en && (pcnt >= div_act);
  assign wrap = tick && (cnt >= top_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (tick) begin
      pcnt <= '0;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end else if (en) begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cascade_timer_trig.sv
module cascade_timer_trig
  import cascade_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_val,
  input  logic         pol,
  input  logic [2:0]   mm,
  input  logic         tick,
  input  logic         wrap,
  output logic         oc_ref,
  output logic         trig
);
  logic uev_hold;
  logic ref_next;
  logic trig_next;

  assign ref_next = (cnt < cmp_val) ^ pol;

  always_comb begin
    if (mm == MM_UPDATE)  trig_next = uev_hold;
    else if (mm[2])       trig_next = oc_ref;
    else                  trig_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uev_hold <= 1'b0;
      oc_ref   <= 1'b0;
      trig     <= 1'b0;
    end else begin
      if (tick) uev_hold <= wrap;
      oc_ref <= ref_next;
      trig   <= trig_next;
    end
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      cnt_o,
  output logic              oc_ref_o,
  output logic              trig_o
);
  ctrl_t        ctrl;
  logic [W-1:0] div_act;
  logic [W-1:0] top_act;
  logic [W-1:0] cmp_val;
  logic         tick;
  logic         wrap;

  cascade_timer_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .upd     (wrap),
    .ctrl    (ctrl),
    .div_act (div_act),
    .top_act (top_act),
    .cmp_val (cmp_val)
  );

  cascade_timer_cnt #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl.en),
    .div_act (div_act),
    .top_act (top_act),
    .cnt     (cnt_o),
    .tick    (tick),
    .wrap    (wrap)
  );

  cascade_timer_trig #(.W(W)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_o),
    .cmp_val (cmp_val),
    .pol     (ctrl.pol),
    .mm      (ctrl.mm),
    .tick    (tick),
    .wrap    (wrap),
    .oc_ref  (oc_ref_o),
    .trig    (trig_o)
  );
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] cnt,
  input logic         tick,
  input logic         wrap,
  input logic [W-1:0] div_act,
  input logic [W-1:0] cmp_val,
  input logic         pol,
  input logic [2:0]   mm,
  input logic         oc_ref,
  input logic         trig
);
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && div_act != '0) |=> (!tick || div_act == '0));

  p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  p_zero_cmp_low_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_val == '0 && !pol) |=> !oc_ref);

  p_trig_follows_ref_r11: assert property (@(posedge clk) disable iff (rst)
    mm[2] |=> (trig == $past(oc_ref)));

  p_other_codes_low_r10: assert property (@(posedge clk) disable iff (rst)
    (mm != 3'b010 && !mm[2]) |=> !trig);
endmodule

bind cascade_timer cascade_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (ctrl.en),
  .cnt     (cnt_o),
  .tick    (tick),
  .wrap    (wrap),
  .div_act (div_act),
  .cmp_val (cmp_val),
  .pol     (ctrl.pol),
  .mm      (ctrl.mm),
  .oc_ref  (oc_ref_o),
  .trig    (trig_o)
);

// File: tb/sim_cascade_timer.sv
module sim_cascade_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic        oc_ref_o;
  logic        trig_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cascade_timer #(.W(16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .oc_ref_o(oc_ref_o), .trig_o(trig_o)
  );

  // kind: 0 periodic, 1 flat low, 2 flat high
  typedef struct packed {
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] cmp;
    logic [2:0]  mm;
    logic        pol;
    logic [1:0]  kind;
    logic [7:0]  per;
    logic [7:0]  wid;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd2, 16'd4, 16'd0, 3'b010, 1'b0, 2'd0, 8'd15, 8'd3},
    '{16'd0, 16'd7, 16'd3, 3'b100, 1'b0, 2'd0, 8'd8,  8'd3},
    '{16'd1, 16'd5, 16'd2, 3'b111, 1'b0, 2'd0, 8'd12, 8'd4},
    '{16'd2, 16'd3, 16'd1, 3'b101, 1'b1, 2'd0, 8'd12, 8'd9},
    '{16'd1, 16'd4, 16'd0, 3'b100, 1'b0, 2'd1, 8'd0,  8'd0},
    '{16'd0, 16'd4, 16'd9, 3'b110, 1'b0, 2'd2, 8'd0,  8'd0},
    '{16'd0, 16'd3, 16'd2, 3'b011, 1'b0, 2'd1, 8'd0,  8'd0},
    '{16'd0, 16'd3, 16'd2, 3'b001, 1'b0, 2'd1, 8'd0,  8'd0}
  };

  localparam int WIN = 64;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control word: bit0 enable, bits3:1 mode, bit4 polarity (R2)
  task automatic setup(input logic [15:0] p, input logic [15:0] a,
                       input logic [15:0] c, input logic [2:0] m, input logic pl);
    wr(2'd0, 16'd0);
    wr(2'd1, p);
    wr(2'd2, a);
    wr(2'd3, c);
    wr(2'd0, {11'd0, pl, m, 1'b1});
  endtask

  task automatic measure(input int settle, output int rises, output int ones,
                         output int period, output int width);
    int r1, r2, f1;
    logic prev;
    repeat (settle) @(negedge clk);
    prev = trig_o; r1 = -1; r2 = -1; f1 = -1; rises = 0; ones = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (trig_o) ones++;
      if (trig_o && !prev) begin
        rises++;
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
      if (!trig_o && prev && r1 >= 0 && f1 < 0) f1 = i;
      prev = trig_o;
    end
    period = (r2 >= 0) ? r2 - r1 : 0;
    width  = (f1 >= 0) ? f1 - r1 : 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises, ones, per, wid;
    int c0, c1, mis_t, mis_r;
    logic pref;
    logic [15:0] pcnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cnt_o == 16'd0, "R1 counter", cnt_o, 0);
    chk(oc_ref_o == 1'b0, "R1 compare ref", oc_ref_o, 0);
    chk(trig_o == 1'b0, "R1 trigger", trig_o, 0);

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].psc, VECS[v].arr, VECS[v].cmp, VECS[v].mm, VECS[v].pol);
      measure(48, rises, ones, per, wid);
      if (VECS[v].kind == 2'd0) begin
        chk(per == int'(VECS[v].per),
            (VECS[v].mm == 3'b010) ? "R8 R2 period" : "R9 R7 period", per, VECS[v].per);
        chk(wid == int'(VECS[v].wid),
            (VECS[v].mm == 3'b010) ? "R8 R4 width" : "R9 R7 width", wid, VECS[v].wid);
      end else if (VECS[v].kind == 2'd1) begin
        chk(ones == 0, "R10 R7 flat low", ones, 0);
      end else begin
        chk(ones == WIN, "R9 R7 flat high", ones, WIN);
      end
    end

    // R4: divide by 4 -> 10 advances in 40 clocks
    setup(16'd3, 16'd1000, 16'd0, 3'b000, 1'b0);
    repeat (8) @(negedge clk);
    c0 = cnt_o;
    repeat (40) @(negedge clk);
    c1 = cnt_o;
    chk(c1 - c0 == 10, "R4 count rate", c1 - c0, 10);

    // R3: disabled counter holds
    wr(2'd0, 16'd0);
    c0 = cnt_o;
    repeat (20) @(negedge clk);
    chk(cnt_o == c0[15:0], "R3 hold while disabled", cnt_o, c0);

    // R6 / R5: reload written while running waits for update
    setup(16'd0, 16'd100, 16'd0, 3'b010, 1'b0);
    repeat (2) @(negedge clk);
    wr(2'd2, 16'd3);
    repeat (4) @(negedge clk);
    chk(cnt_o > 16'd3, "R6 reload deferred", cnt_o, 4);
    repeat (120) @(negedge clk);
    c1 = 0; c0 = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (int'(cnt_o) > c1) c1 = cnt_o;
      if (cnt_o == 16'd0) c0++;
    end
    chk(c1 == 3, "R6 R5 new reload applied", c1, 3);
    chk(c0 == 2, "R5 wraps to zero", c0, 2);

    // R11 / R7: cycle-exact lag
    setup(16'd0, 16'd7, 16'd3, 3'b100, 1'b0);
    repeat (20) @(negedge clk);
    pref = oc_ref_o; pcnt = cnt_o; mis_t = 0; mis_r = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (trig_o != pref) mis_t++;
      if (oc_ref_o != (pcnt < 16'd3)) mis_r++;
      pref = oc_ref_o; pcnt = cnt_o;
    end
    chk(mis_t == 0, "R11 trigger lag", mis_t, 0);
    chk(mis_r == 0, "R7 reference vs counter", mis_r, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule